// File: doc/BRIEF.md
# Vectored Priority Interrupt Resolver

This block chooses which pending IRQ goes to the processor. It looks at 32 masked request lines and one request chained in from a downstream controller. Each requester has a 4-bit priority level, and level 0 is the most urgent. A 16-bit level mask can block whole levels. The block then presents the service-routine address of the winning requester. Each of the 32 sources has its own vector address register. The chained requester supplies its vector address on an input.

Service is nested. A read of the current-vector register returns the winning address and acknowledges the interrupt. That read also marks the winner's level as in service, and from then on only a strictly more urgent level can raise the request again. A write of any value to the same register ends service of the most urgent level in service, so the level it had preempted becomes current once more. The current-vector register holds the last acknowledged address and starts at zero.

The register bus uses 7-bit word addresses. Bits [6:5] select the region. Region 00 is control: offset 0 is the current vector, offset 1 is the level mask and offset 2 is the chained requester's priority. Region 10 is the vector table and region 11 is the priority table, each indexed by bits [4:0]. Region 01 reads as zero.

Top module: `vpir_top`

## Requirements
- R1: After reset, irq_req and vec_addr are 0, every priority entry reads 15, the chained priority reads 15, the level mask reads 0xFFFF and the current vector reads 0.
- R2: Among eligible requesters, the one with the numerically lowest priority level wins and its vector appears on vec_addr.
- R3: When several eligible requesters share the winning level, the lowest source index wins. The chained requester ranks below source 31 in a tie.
- R4: A requester whose level has a 0 in the level mask is not eligible. With the mask at zero, irq_req stays low.
- R5: A read of the current vector (control offset 0) returns vec_addr and, if irq_req is high, marks the winner's level in service. From then on, irq_req is high only for an eligible requester whose level is strictly lower in number than every level in service.
- R6: A write of any value to the current vector removes the most urgent level in service, which restores the level it had preempted.
- R7: A read of the current vector while irq_req is low returns the last acknowledged address and changes no in-service state. vec_addr shows that held address whenever irq_req is low.
- R8: Accesses to the vector table, the priority table and the chained priority take one wait state (bus_ready rises in the second cycle). Accesses to the current vector and the level mask complete in the first cycle.
- R9: Priority entries keep bits [3:0] and read zero above them. The level mask keeps bits [15:0] and reads zero above them. Vector entries keep all 32 bits.
- R10: When the chained requester wins, vec_addr equals daisy_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_pend | input | 32 | Masked IRQ request per source |
| daisy_req | input | 1 | Request from the chained controller |
| daisy_vec | input | 32 | Vector address of the chained request |
| bus_sel | input | 1 | Access request, held until bus_ready |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready |
| bus_ready | output | 1 | Access completes at this clock edge |
| irq_req | output | 1 | Interrupt request to the processor |
| vec_addr | output | 32 | Address of the winning routine, or the held one |

## Verification
A stale or wrong in-service mask shows up on irq_req as soon as a requester at a nearby level becomes pending. It appears either as a missing preemption or as a repeat request at an equal level, in the same cycle. An end-of-service that pops the wrong level shows only on a later request, so the bench pends new sources after every pop. A wrong held vector appears on vec_addr at once whenever irq_req is low. The bench's cycle model therefore compares both outputs on every clock.

// File: rtl/vpir_pkg.sv
package vpir_pkg;
  localparam int NSRC_DEF = 32;
  localparam int NLVL_DEF = 16;
  localparam int DW_DEF   = 32;

  typedef enum logic [1:0] {
    RG_CTRL = 2'b00,
    RG_NONE = 2'b01,
    RG_VEC  = 2'b10,
    RG_PRIO = 2'b11
  } region_e;

  localparam int CTL_CUR   = 0;
  localparam int CTL_MASK  = 1;
  localparam int CTL_DAISY = 2;
endpackage

// File: rtl/vpir_regs.sv
module vpir_regs
  import vpir_pkg::*;
#(
  parameter int NSRC = NSRC_DEF,
  parameter int NLVL = NLVL_DEF,
  parameter int DW   = DW_DEF,
  localparam int PW  = $clog2(NLVL),
  localparam int IW  = $clog2(NSRC),
  localparam int AW  = IW + 2,
  localparam int NIN = NSRC + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [AW-1:0]            bus_addr,
  input  logic [DW-1:0]            bus_wdata,
  input  logic [DW-1:0]            cur_rdata,
  output logic [DW-1:0]            bus_rdata,
  output logic                     bus_ready,
  output logic [NIN-1:0][PW-1:0]   prio,
  output logic [NSRC-1:0][DW-1:0]  vecs,
  output logic [NLVL-1:0]          lvl_mask,
  output logic                     ack_rd,
  output logic                     eos_wr
);
  region_e         region;
  logic [IW-1:0]   idx;
  logic            is_ctl_cur, is_ctl_mask, is_ctl_daisy;
  logic            slow, wait_q, done;

  assign region       = region_e'(bus_addr[AW-1:AW-2]);
  assign idx          = bus_addr[IW-1:0];
  assign is_ctl_cur   = (region == RG_CTRL) && (idx == IW'(CTL_CUR));
  assign is_ctl_mask  = (region == RG_CTRL) && (idx == IW'(CTL_MASK));
  assign is_ctl_daisy = (region == RG_CTRL) && (idx == IW'(CTL_DAISY));
  assign slow         = (region == RG_VEC) || (region == RG_PRIO) || is_ctl_daisy;
  assign bus_ready    = bus_sel && (!slow || wait_q);
  assign done         = bus_ready;
  assign ack_rd       = done && !bus_wr && is_ctl_cur;
  assign eos_wr       = done &&  bus_wr && is_ctl_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q   <= 1'b0;
      lvl_mask <= '1;
      prio     <= '{default: '1};
      vecs     <= '0;
    end else begin
      wait_q <= bus_sel && slow && !wait_q;
      if (done && bus_wr) begin
        if (is_ctl_mask)       lvl_mask      <= bus_wdata[NLVL-1:0];
        if (is_ctl_daisy)      prio[NSRC]    <= bus_wdata[PW-1:0];
        if (region == RG_VEC)  vecs[idx]     <= bus_wdata;
        if (region == RG_PRIO) prio[idx]     <= bus_wdata[PW-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (region)
      RG_CTRL: begin
        if (is_ctl_cur)   bus_rdata = cur_rdata;
        if (is_ctl_mask)  bus_rdata[NLVL-1:0] = lvl_mask;
        if (is_ctl_daisy) bus_rdata[PW-1:0] = prio[NSRC];
      end
      RG_VEC:  bus_rdata = vecs[idx];
      RG_PRIO: bus_rdata[PW-1:0] = prio[idx];
      default: bus_rdata = '0;
    endcase
  end

  // R8: a slow access never completes in its first cycle, and it completes in its second
  assert_slow_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && slow && !wait_q) |-> !bus_ready)
    else $error("slow access completed without wait state");
  assert_slow_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && slow && !bus_ready) |=> (!bus_sel || bus_ready))
    else $error("slow access took more than one wait state");
endmodule

// File: rtl/vpir_arbiter.sv
module vpir_arbiter
  import vpir_pkg::*;
#(
  parameter int NSRC = NSRC_DEF,
  parameter int NLVL = NLVL_DEF,
  localparam int PW  = $clog2(NLVL),
  localparam int NIN = NSRC + 1,
  localparam int XW  = $clog2(NIN)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NIN-1:0]          pend,
  input  logic [NIN-1:0][PW-1:0]  prio,
  input  logic [NLVL-1:0]         lvl_mask,
  output logic                    found,
  output logic [PW-1:0]           win_lvl,
  output logic [XW-1:0]           win_idx
);
  logic [NIN-1:0] eligible;

  for (genvar g = 0; g < NIN; g++) begin : g_elig
    assign eligible[g] = pend[g] && lvl_mask[prio[g]];
  end

  // Walk from the highest index down so that a tie resolves to the lowest index.
  always_comb begin
    found   = 1'b0;
    win_lvl = '1;
    win_idx = '0;
    for (int i = NIN - 1; i >= 0; i--) begin
      if (eligible[i] && (!found || prio[i] <= win_lvl)) begin
        found   = 1'b1;
        win_lvl = prio[i];
        win_idx = XW'(i);
      end
    end
  end

  // R4: the chosen requester is pending and its level is unmasked
  assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (pend[win_idx] && lvl_mask[win_lvl]))
    else $error("winner not eligible");
endmodule

// File: rtl/vpir_nest.sv
module vpir_nest
  import vpir_pkg::*;
#(
  parameter int NLVL = NLVL_DEF,
  parameter int DW   = DW_DEF,
  localparam int PW  = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            found,
  input  logic [PW-1:0]   win_lvl,
  input  logic [DW-1:0]   win_vec,
  input  logic            ack_rd,
  input  logic            eos_wr,
  output logic            qualify,
  output logic [DW-1:0]   vec_out
);
  logic [NLVL-1:0] in_svc;
  logic [DW-1:0]   held;
  logic [PW:0]     top_lvl;
  logic            ack_take;

  // Most urgent level in service, NLVL when none.
  function automatic logic [PW:0] top_of(input logic [NLVL-1:0] m);
    logic [PW:0] r;
    r = (PW+1)'(NLVL);
    for (int l = NLVL - 1; l >= 0; l--) if (m[l]) r = (PW+1)'(l);
    return r;
  endfunction

  // Clearing the lowest set bit drops the most urgent level.
  function automatic logic [NLVL-1:0] pop_top(input logic [NLVL-1:0] m);
    return m & (m - NLVL'(1));
  endfunction

  assign top_lvl  = top_of(in_svc);
  assign qualify  = found && ({1'b0, win_lvl} < top_lvl);
  assign vec_out  = qualify ? win_vec : held;
  assign ack_take = ack_rd && qualify;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_svc <= '0;
      held   <= '0;
    end else if (ack_take) begin
      in_svc[win_lvl] <= 1'b1;
      held            <= win_vec;
    end else if (eos_wr) begin
      in_svc <= pop_top(in_svc);
    end
  end

  // R5: an acknowledge leaves the winner's level in service
  assert_ack_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> in_svc[$past(win_lvl)])
    else $error("acknowledged level not in service");
  // R6: end of service removes exactly one level
  assert_eos_pops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_wr && (in_svc != '0)) |=> ($countones(in_svc) == $countones($past(in_svc)) - 1))
    else $error("end of service did not remove one level");
  // R7: an idle acknowledge read changes nothing
  assert_idle_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !qualify) |=> ($stable(in_svc) && $stable(held)))
    else $error("idle read changed state");
endmodule

// File: rtl/vpir_top.sv
module vpir_top
  import vpir_pkg::*;
#(
  parameter int NSRC = NSRC_DEF,
  parameter int NLVL = NLVL_DEF,
  parameter int DW   = DW_DEF,
  localparam int PW  = $clog2(NLVL),
  localparam int IW  = $clog2(NSRC),
  localparam int AW  = IW + 2,
  localparam int NIN = NSRC + 1,
  localparam int XW  = $clog2(NIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_pend,
  input  logic            daisy_req,
  input  logic [DW-1:0]   daisy_vec,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            bus_ready,
  output logic            irq_req,
  output logic [DW-1:0]   vec_addr
);
  logic [NIN-1:0][PW-1:0]  prio;
  logic [NSRC-1:0][DW-1:0] vecs;
  logic [NLVL-1:0]         lvl_mask;
  logic                    ack_rd, eos_wr, found, qualify;
  logic [PW-1:0]           win_lvl;
  logic [XW-1:0]           win_idx;
  logic [DW-1:0]           win_vec, cur_vec;

  assign win_vec = (win_idx == XW'(NSRC)) ? daisy_vec : vecs[win_idx[IW-1:0]];

  vpir_regs #(.NSRC(NSRC), .NLVL(NLVL), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cur_rdata(cur_vec),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .prio(prio), .vecs(vecs),
    .lvl_mask(lvl_mask), .ack_rd(ack_rd), .eos_wr(eos_wr)
  );

  vpir_arbiter #(.NSRC(NSRC), .NLVL(NLVL)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend({daisy_req, irq_pend}), .prio(prio),
    .lvl_mask(lvl_mask), .found(found), .win_lvl(win_lvl), .win_idx(win_idx)
  );

  vpir_nest #(.NLVL(NLVL), .DW(DW)) u_nest (
    .clk(clk), .rst_n(rst_n), .found(found), .win_lvl(win_lvl), .win_vec(win_vec),
    .ack_rd(ack_rd), .eos_wr(eos_wr), .qualify(qualify), .vec_out(cur_vec)
  );

  assign irq_req  = qualify;
  assign vec_addr = cur_vec;
endmodule

// File: tb/sim_vpir_top.sv
`timescale 1ns/100ps
module sim_vpir_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_pend = '0;
  logic        daisy_req = 1'b0;
  logic [31:0] daisy_vec = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, irq_req;
  logic [31:0] vec_addr;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // reference state
  int          rprio[33];
  logic [31:0] rvec[32];
  logic [15:0] rmask;
  int          svc[$];
  logic [31:0] rheld;

  localparam logic [6:0] A_CUR = 7'h00, A_MASK = 7'h01, A_DAISY = 7'h02;
  localparam logic [6:0] A_VEC = 7'h40, A_PRIO = 7'h60;

  vpir_top u0 (.*);

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit pend_of(input int i);
    return (i == 32) ? daisy_req : irq_pend[i];
  endfunction

  function automatic bit ref_qual(output logic [31:0] v);
    int top;
    top = (svc.size() == 0) ? 16 : svc[$];
    for (int l = 0; l < 16; l++) begin
      if (rmask[l]) begin
        for (int i = 0; i < 33; i++) begin
          if (pend_of(i) && rprio[i] == l) begin
            v = (i == 32) ? daisy_vec : rvec[i];
            if (l < top) return 1'b1;
            v = rheld;
            return 1'b0;
          end
        end
      end
    end
    v = rheld;
    return 1'b0;
  endfunction

  function automatic int ref_lvl();
    for (int l = 0; l < 16; l++)
      if (rmask[l])
        for (int i = 0; i < 33; i++)
          if (pend_of(i) && rprio[i] == l) return l;
    return 16;
  endfunction

  // every-cycle comparison against the model (R5, R7)
  always @(negedge clk) begin
    logic [31:0] ev;
    bit q;
    if (rst_n && !finished) begin
      q = ref_qual(ev);
      chk("R5 irq_req per cycle", {31'b0, irq_req}, {31'b0, q});
      chk("R7 vec_addr per cycle", vec_addr, ev);
    end
  end

  // one bus access; starts and ends just after a rising edge
  task automatic xfer(input bit w, input logic [6:0] a, input logic [31:0] d,
                      output logic [31:0] q);
    int waits = 0;
    bit slow;
    bit qual;
    logic [31:0] ev;
    slow = (a[6:5] == 2'b10) || (a[6:5] == 2'b11) || (a == A_DAISY);
    bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    while (!bus_ready && waits < 8) begin waits++; @(negedge clk); end
    q = bus_rdata;
    chk("R8 wait states", waits, slow ? 1 : 0);
    qual = ref_qual(ev);
    @(posedge clk); #0.5;
    bus_sel = 1'b0; bus_wr = 1'b0;
    // model update
    if (w) begin
      if (a == A_CUR && svc.size() > 0) void'(svc.pop_back());
      if (a == A_MASK) rmask = d[15:0];
      if (a == A_DAISY) rprio[32] = d[3:0];
      if (a[6:5] == 2'b10) rvec[a[4:0]] = d;
      if (a[6:5] == 2'b11) rprio[a[4:0]] = d[3:0];
    end else if (a == A_CUR && qual) begin
      svc.push_back(ref_lvl());
      rheld = ev;
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    logic [31:0] q;
    xfer(1'b1, a, d, q);
  endtask

  task automatic rd(input string req, input logic [6:0] a, input logic [31:0] exp);
    logic [31:0] q;
    xfer(1'b0, a, 32'h0, q);
    chk(req, q, exp);
  endtask

  task automatic look(input string req, input bit e_irq, input logic [31:0] e_vec);
    @(negedge clk);
    chk(req, {31'b0, irq_req}, {31'b0, e_irq});
    chk(req, vec_addr, e_vec);
    @(posedge clk); #0.5;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
  end

  initial begin
    for (int i = 0; i < 33; i++) rprio[i] = 15;
    for (int i = 0; i < 32; i++) rvec[i] = '0;
    rmask = 16'hFFFF; rheld = '0;
    repeat (4) @(posedge clk);
    #0.5 rst_n = 1'b1;
    // R1 reset state
    look("R1 reset outputs", 1'b0, 32'h0);
    rd("R1 priority reset", A_PRIO | 7'd5, 32'd15);
    rd("R1 mask reset", A_MASK, 32'h0000FFFF);
    rd("R1 chained priority reset", A_DAISY, 32'd15);
    rd("R1 current vector reset", A_CUR, 32'h0);
    // vector table
    for (int i = 0; i < 32; i++) wr(A_VEC | 7'(i), 32'h1000 + 32'(i) * 16);
    rd("R9 vector readback", A_VEC | 7'd7, 32'h1070);
    wr(A_PRIO | 7'd20, 32'hFFFFFFF3);
    rd("R9 priority width", A_PRIO | 7'd20, 32'h3);
    wr(A_PRIO | 7'd20, 32'd15);
    wr(A_MASK, 32'hFFFF0FF0);
    rd("R9 mask width", A_MASK, 32'h00000FF0);
    wr(A_MASK, 32'h0000FFFF);
    // ties and priority
    irq_pend = (32'h1 << 4) | (32'h1 << 9);
    look("R3 tie lowest index", 1'b1, 32'h1040);
    wr(A_PRIO | 7'd9, 32'd2);
    look("R2 lower level wins", 1'b1, 32'h1090);
    irq_pend = 32'h1 << 31; daisy_req = 1'b1; daisy_vec = 32'hDEAD0000;
    look("R3 chained ranks below 31", 1'b1, 32'h11F0);
    wr(A_DAISY, 32'd1);
    look("R10 chained vector", 1'b1, 32'hDEAD0000);
    daisy_req = 1'b0;
    // level mask
    irq_pend = (32'h1 << 4) | (32'h1 << 9);
    wr(A_MASK, 32'h0000FFFB);
    look("R4 masked level skipped", 1'b1, 32'h1040);
    wr(A_MASK, 32'h0);
    look("R4 all levels masked", 1'b0, 32'h0);
    wr(A_MASK, 32'h0000FFFF);
    // nesting
    irq_pend = 32'h1 << 3;
    wr(A_PRIO | 7'd3, 32'd8);
    wr(A_PRIO | 7'd6, 32'd8);
    wr(A_PRIO | 7'd10, 32'd5);
    look("R2 single source", 1'b1, 32'h1030);
    rd("R5 ack returns vector", A_CUR, 32'h1030);
    look("R5 in service blocks same source", 1'b0, 32'h1030);
    irq_pend = irq_pend | (32'h1 << 6);
    look("R5 equal level no preempt", 1'b0, 32'h1030);
    irq_pend = irq_pend | (32'h1 << 10);
    look("R5 higher level preempts", 1'b1, 32'h10A0);
    rd("R5 nested ack", A_CUR, 32'h10A0);
    look("R5 nested in service", 1'b0, 32'h10A0);
    wr(A_CUR, 32'h12345678);
    look("R6 pop restores level 8", 1'b1, 32'h10A0);
    irq_pend = irq_pend & ~(32'h1 << 10);
    look("R6 level 8 still in service", 1'b0, 32'h10A0);
    wr(A_CUR, 32'h0);
    look("R6 pop to idle", 1'b1, 32'h1030);
    // idle read
    irq_pend = '0;
    look("R7 held vector", 1'b0, 32'h10A0);
    rd("R7 idle read returns held", A_CUR, 32'h10A0);
    irq_pend = 32'h1 << 6;
    look("R7 idle read marked nothing", 1'b1, 32'h1060);
    report();
  end
endmodule